// File: doc/BRIEF.md
# Four-Register Single-Cycle Datapath

This block is the operand-and-result path of a small processor. It holds four W-bit registers, 8 bits by default. Two independent read selectors place one register on the A bus and one on the B bus. The B bus can instead carry a constant supplied by the controller. A function unit works on these buses. It holds an adder-based arithmetic/logic unit and a one-bit shifter that acts on the B bus. A write-back selector then picks either the function-unit result or external data, such as a memory word, and that value is loaded into the destination register on the next rising clock edge.

An outside controller drives the operand selects, the constant select, the 4-bit function code, the shifter select and direction, the write-back select, the destination address and the write enable. A whole micro-operation completes in one clock: operand read, execution and write-back. The A bus leaves the block as an address output and the B bus leaves it as a data output. Four combinational status bits (overflow, carry, negative, zero) go back to the controller.

Top module: `regpath_top`

## Requirements
- R1: After reset every register reads as zero on both buses.
- R2: With `wr_en` high, the register named by `dst_sel` takes the write-back value at the rising edge, and the other three registers keep their contents.
- R3: With `wr_en` low, no register changes, whatever `dst_sel`, `ext_data` and the function inputs hold.
- R4: `addr_out` always shows the register picked by `a_sel`. `data_out` shows the register picked by `b_sel` when `b_const_sel` is 0, and `const_in` when it is 1.
- R5: When `fn_code[3]` is 0, the ALU result is A + Y + `fn_code[0]`. Y depends on `fn_code[2:1]`: 00 gives zero, 01 gives B, 10 gives the bitwise inverse of B, and 11 gives all ones.
- R6: When `fn_code[3]` is 1, `fn_code[0]` is ignored. `fn_code[2:1]` then picks the result: 00 is A AND B, 01 is A OR B, 10 is A XOR B, and 11 is NOT A.
- R7: When `shift_sel` is 1, the function-unit output is the B bus shifted by one place, left when `shift_left` is 1 and right when it is 0. A zero enters at the vacated end and the bit shifted out is lost.
- R8: When `wb_ext_sel` is 1, the write-back value is `ext_data`. When it is 0, the write-back value is the function-unit output.
- R9: During arithmetic, `flag_c` is the carry out of the W-bit addition. `flag_v` is 1 when the two addend operands share a sign bit and the sum's sign bit differs from it. Both flags are 0 for logic operations and whenever the shifter is selected.
- R10: `flag_n` is the top bit of the function-unit output. `flag_z` is 1 exactly when that output is zero. Both are combinational in the same cycle.
- R11: A register read in the same cycle it is written shows the old value. The new value appears from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_sel | input | 2 | Register placed on the A bus |
| b_sel | input | 2 | Register placed on the B bus |
| b_const_sel | input | 1 | 1: B bus carries const_in |
| const_in | input | W | Constant operand |
| fn_code | input | 4 | ALU function: [3] logic/arith, [2:1] op, [0] carry-in |
| shift_sel | input | 1 | 1: function output from shifter |
| shift_left | input | 1 | Shifter direction, 1 = left |
| wb_ext_sel | input | 1 | 1: write back ext_data |
| ext_data | input | W | External write-back data |
| dst_sel | input | 2 | Destination register |
| wr_en | input | 1 | Register load enable |
| addr_out | output | W | A bus |
| data_out | output | W | B bus |
| flag_v | output | 1 | Signed overflow |
| flag_c | output | 1 | Carry out |
| flag_n | output | 1 | Result negative |
| flag_z | output | 1 | Result zero |

## Verification
The registers are reachable only through the two read buses, and a write lands one edge after its operands are read. The awkward case is therefore a read and a write to the same register in one cycle. The stimulus does exactly that: it loads a register while selecting it on both buses, then reads it again in the next vector to show the old value and then the new one. Overflow and carry corners need operands near the sign boundary. For this reason the registers are first filled from `ext_data` with 0x7F, 0x81 and 0xFF before the arithmetic sweep.

// File: rtl/regpath_pkg.sv
package regpath_pkg;
  // arithmetic addend select, fn_code[2:1]
  typedef enum logic [1:0] {
    Y_ZERO = 2'b00,
    Y_B    = 2'b01,
    Y_NOTB = 2'b10,
    Y_ONES = 2'b11
  } ysel_e;

  // logic op select, fn_code[2:1]
  typedef enum logic [1:0] {
    LG_AND = 2'b00,
    LG_OR  = 2'b01,
    LG_XOR = 2'b10,
    LG_NOT = 2'b11
  } lsel_e;
endpackage

// File: rtl/regpath_rf.sv
module regpath_rf #(
  parameter int W    = 8,
  parameter int NREG = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr_a,
  input  logic [AW-1:0] raddr_b,
  output logic [W-1:0]  rdata_a,
  output logic [W-1:0]  rdata_b
);
  logic [W-1:0] regs_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic         ld;
    logic [W-1:0] nxt;

    assign ld = we && (waddr == AW'(i));

    always_comb begin
      nxt = regs_q[i];
      if (ld) nxt = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[i] <= '0;
      else        regs_q[i] <= nxt;
    end
  end

  assign rdata_a = regs_q[raddr_a];
  assign rdata_b = regs_q[raddr_b];
endmodule

// File: rtl/regpath_alu.sv
module regpath_alu
  import regpath_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [3:0]   fn,
  output logic [W-1:0] res,
  output logic         cout,
  output logic         ovf
);
  logic [W-1:0] yop;
  logic [W:0]   sum;
  logic [W-1:0] lres;

  always_comb begin
    unique case (ysel_e'(fn[2:1]))
      Y_ZERO:  yop = '0;
      Y_B:     yop = b;
      Y_NOTB:  yop = ~b;
      default: yop = '1;
    endcase
    sum = {1'b0, a} + {1'b0, yop} + {{W{1'b0}}, fn[0]};
  end

  always_comb begin
    unique case (lsel_e'(fn[2:1]))
      LG_AND:  lres = a & b;
      LG_OR:   lres = a | b;
      LG_XOR:  lres = a ^ b;
      default: lres = ~a;
    endcase
  end

  always_comb begin
    if (fn[3]) begin
      res  = lres;
      cout = 1'b0;
      ovf  = 1'b0;
    end else begin
      res  = sum[W-1:0];
      cout = sum[W];
      ovf  = (a[W-1] == yop[W-1]) && (sum[W-1] != a[W-1]);
    end
  end
endmodule

// File: rtl/regpath_shift.sv
module regpath_shift #(
  parameter int W = 8
) (
  input  logic [W-1:0] din,
  input  logic         left,
  output logic [W-1:0] dout
);
  always_comb begin
    if (left) dout = {din[W-2:0], 1'b0};
    else      dout = {1'b0, din[W-1:1]};
  end
endmodule

// File: rtl/regpath_top.sv
module regpath_top #(
  parameter int W    = 8,
  parameter int NREG = 4,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] a_sel,
  input  logic [AW-1:0] b_sel,
  input  logic          b_const_sel,
  input  logic [W-1:0]  const_in,
  input  logic [3:0]    fn_code,
  input  logic          shift_sel,
  input  logic          shift_left,
  input  logic          wb_ext_sel,
  input  logic [W-1:0]  ext_data,
  input  logic [AW-1:0] dst_sel,
  input  logic          wr_en,
  output logic [W-1:0]  addr_out,
  output logic [W-1:0]  data_out,
  output logic          flag_v,
  output logic          flag_c,
  output logic          flag_n,
  output logic          flag_z
);
  // reset: asserted asynchronously, released after two edges
  logic [1:0] rsync_q;
  logic       sync_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign sync_rst_n = rsync_q[1];

  logic [W-1:0] bus_a, reg_b, bus_b;
  logic [W-1:0] alu_res, sh_res, fn_out, wb_data;
  logic         alu_c, alu_v;

  regpath_rf #(.W(W), .NREG(NREG)) u_rf (
    .clk     (clk),
    .rst_n   (sync_rst_n),
    .we      (wr_en),
    .waddr   (dst_sel),
    .wdata   (wb_data),
    .raddr_a (a_sel),
    .raddr_b (b_sel),
    .rdata_a (bus_a),
    .rdata_b (reg_b)
  );

  assign bus_b = b_const_sel ? const_in : reg_b;

  regpath_alu #(.W(W)) u_alu (
    .a    (bus_a),
    .b    (bus_b),
    .fn   (fn_code),
    .res  (alu_res),
    .cout (alu_c),
    .ovf  (alu_v)
  );

  regpath_shift #(.W(W)) u_sh (
    .din  (bus_b),
    .left (shift_left),
    .dout (sh_res)
  );

  always_comb begin
    fn_out = shift_sel ? sh_res : alu_res;
    flag_c = shift_sel ? 1'b0 : alu_c;
    flag_v = shift_sel ? 1'b0 : alu_v;
    flag_n = fn_out[W-1];
    flag_z = (fn_out == '0);
    wb_data = wb_ext_sel ? ext_data : fn_out;
  end

  assign addr_out = bus_a;
  assign data_out = bus_b;
endmodule

// File: rtl/regpath_chk.sv
module regpath_chk #(
  parameter int W    = 8,
  parameter int NREG = 4,
  localparam int AW  = $clog2(NREG)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          sync_rst_n,
  input logic [AW-1:0] a_sel,
  input logic [AW-1:0] dst_sel,
  input logic          wr_en,
  input logic          wb_ext_sel,
  input logic          shift_sel,
  input logic          shift_left,
  input logic [3:0]    fn_code,
  input logic [W-1:0]  ext_data,
  input logic [W-1:0]  wb_data,
  input logic [W-1:0]  addr_out,
  input logic          flag_v,
  input logic          flag_c,
  input logic          flag_z
);
  // R2
  wr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && sync_rst_n) |=> (a_sel != $past(dst_sel)) || (addr_out == $past(wb_data)));

  // R3
  no_wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(!wr_en) && $stable(a_sel)) |-> $stable(addr_out));

  // R8
  ext_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wb_ext_sel && sync_rst_n) |=> (a_sel != $past(dst_sel)) || (addr_out == $past(ext_data)));

  // R9
  shift_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_sel |-> (!flag_v && !flag_c));

  // R9
  logic_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fn_code[3] |-> (!flag_v && !flag_c));

  // R10
  zero_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wb_ext_sel && flag_z && sync_rst_n) |=> (a_sel != $past(dst_sel)) || (addr_out == '0));

  // R7
  shr_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wb_ext_sel && shift_sel && !shift_left && sync_rst_n) |=> (a_sel != $past(dst_sel)) || !addr_out[W-1]);
endmodule

bind regpath_top regpath_chk #(.W(W), .NREG(NREG)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .sync_rst_n (sync_rst_n),
  .a_sel      (a_sel),
  .dst_sel    (dst_sel),
  .wr_en      (wr_en),
  .wb_ext_sel (wb_ext_sel),
  .shift_sel  (shift_sel),
  .shift_left (shift_left),
  .fn_code    (fn_code),
  .ext_data   (ext_data),
  .wb_data    (wb_data),
  .addr_out   (addr_out),
  .flag_v     (flag_v),
  .flag_c     (flag_c),
  .flag_z     (flag_z)
);

// File: tb/sim_regpath_top.sv
module sim_regpath_top;
  localparam int W  = 8;
  localparam int AW = 2;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic          rst_n;
  logic [AW-1:0] a_sel, b_sel, dst_sel;
  logic          b_const_sel, shift_sel, shift_left, wb_ext_sel, wr_en;
  logic [W-1:0]  const_in, ext_data;
  logic [3:0]    fn_code;
  logic [W-1:0]  addr_out, data_out;
  logic          flag_v, flag_c, flag_n, flag_z;

  regpath_top #(.W(W), .NREG(4)) u0 (
    .clk(clk), .rst_n(rst_n), .a_sel(a_sel), .b_sel(b_sel),
    .b_const_sel(b_const_sel), .const_in(const_in), .fn_code(fn_code),
    .shift_sel(shift_sel), .shift_left(shift_left), .wb_ext_sel(wb_ext_sel),
    .ext_data(ext_data), .dst_sel(dst_sel), .wr_en(wr_en),
    .addr_out(addr_out), .data_out(data_out),
    .flag_v(flag_v), .flag_c(flag_c), .flag_n(flag_n), .flag_z(flag_z)
  );

  typedef struct {
    logic [W-1:0] addr;
    logic [W-1:0] data;
    logic [3:0]   vcnz;
    string        req;
  } exp_t;

  exp_t         sbq[$];
  event         sample_ev;
  int           n_vec = 0;
  int           n_bad = 0;
  bit           done  = 0;
  logic [W-1:0] model [4];

  // driver: applies one micro-operation, predicts outputs, updates model
  task automatic apply(input logic [AW-1:0] as, input logic [AW-1:0] bs,
                       input logic mb, input logic [3:0] g, input logic mf,
                       input logic h, input logic md, input logic [AW-1:0] ds,
                       input logic we, input logic [W-1:0] k,
                       input logic [W-1:0] ext, input string req);
    exp_t         e;
    logic [W-1:0] av, bv, yv, fo;
    logic [W:0]   sum;
    logic         cc, vv;
    @(negedge clk);
    a_sel = as; b_sel = bs; b_const_sel = mb; fn_code = g; shift_sel = mf;
    shift_left = h; wb_ext_sel = md; dst_sel = ds; wr_en = we;
    const_in = k; ext_data = ext;
    av = model[as];
    bv = mb ? k : model[bs];
    case (g[2:1])
      2'd0:    yv = '0;
      2'd1:    yv = bv;
      2'd2:    yv = ~bv;
      default: yv = '1;
    endcase
    sum = {1'b0, av} + {1'b0, yv} + {{W{1'b0}}, g[0]};
    if (!g[3]) begin
      fo = sum[W-1:0];
      cc = sum[W];
      vv = (av[W-1] == yv[W-1]) && (fo[W-1] != av[W-1]);
    end else begin
      case (g[2:1])
        2'd0:    fo = av & bv;
        2'd1:    fo = av | bv;
        2'd2:    fo = av ^ bv;
        default: fo = ~av;
      endcase
      cc = 1'b0; vv = 1'b0;
    end
    if (mf) begin
      fo = h ? {bv[W-2:0], 1'b0} : {1'b0, bv[W-1:1]};
      cc = 1'b0; vv = 1'b0;
    end
    e.addr = av;
    e.data = bv;
    e.vcnz = {vv, cc, fo[W-1], (fo == '0)};
    e.req  = req;
    sbq.push_back(e);
    #1;
    ->sample_ev;
    @(posedge clk);
    if (we) model[ds] = md ? ext : fo;
  endtask

  task automatic rd(input logic [AW-1:0] as, input logic [AW-1:0] bs, input string req);
    apply(as, bs, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00, 8'h00, req);
  endtask

  // monitor: compares observed outputs against the queued prediction
  initial begin
    forever begin
      exp_t e;
      @(sample_ev);
      e = sbq.pop_front();
      n_vec++;
      if (addr_out !== e.addr || data_out !== e.data ||
          {flag_v, flag_c, flag_n, flag_z} !== e.vcnz) begin
        n_bad++;
        $display("FAIL %s: got addr=%h data=%h vcnz=%b%b%b%b, expected addr=%h data=%h vcnz=%b",
                 e.req, addr_out, data_out, flag_v, flag_c, flag_n, flag_z,
                 e.addr, e.data, e.vcnz);
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got no completion, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) model[i] = '0;
    rst_n = 1'b0; a_sel = '0; b_sel = '0; dst_sel = '0; b_const_sel = 1'b0;
    shift_sel = 1'b0; shift_left = 1'b0; wb_ext_sel = 1'b0; wr_en = 1'b0;
    const_in = '0; ext_data = '0; fn_code = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset contents
    rd(2'd0, 2'd1, "R1");
    rd(2'd2, 2'd3, "R1");

    // R8: load registers from external data
    apply(2'd0, 2'd0, 0, 4'h0, 0, 0, 1, 2'd0, 1, 8'h00, 8'h5A, "R8");
    apply(2'd0, 2'd0, 0, 4'h0, 0, 0, 1, 2'd1, 1, 8'h00, 8'h81, "R8");
    apply(2'd1, 2'd0, 0, 4'h0, 0, 0, 1, 2'd2, 1, 8'h00, 8'h7F, "R8");
    apply(2'd2, 2'd1, 0, 4'h0, 0, 0, 1, 2'd3, 1, 8'h00, 8'hFF, "R8");
    rd(2'd3, 2'd0, "R8");

    // R11: same-cycle read of the written register shows the old value
    apply(2'd3, 2'd3, 0, 4'h0, 0, 0, 1, 2'd3, 1, 8'h00, 8'h3C, "R11");
    rd(2'd3, 2'd3, "R11");
    apply(2'd3, 2'd3, 0, 4'h0, 0, 0, 1, 2'd3, 1, 8'h00, 8'hFF, "R11");

    // R3: disabled write leaves registers alone
    apply(2'd0, 2'd0, 0, 4'h2, 0, 0, 1, 2'd0, 0, 8'h00, 8'hEE, "R3");
    apply(2'd1, 2'd1, 0, 4'h2, 0, 0, 0, 2'd1, 0, 8'h00, 8'hEE, "R3");
    rd(2'd0, 2'd1, "R3");

    // R4: bus selection and constant operand
    rd(2'd1, 2'd2, "R4");
    apply(2'd3, 2'd2, 1, 4'h0, 0, 0, 0, 2'd0, 0, 8'h33, 8'h00, "R4");

    // R5 / R9: arithmetic sweep with 0x7F and 0x81 operands
    for (int g = 0; g < 8; g++)
      apply(2'd2, 2'd1, 0, 4'(g), 0, 0, 0, 2'd0, 0, 8'h00, 8'h00, "R5");
    apply(2'd2, 2'd0, 0, 4'h1, 0, 0, 0, 2'd0, 0, 8'h00, 8'h00, "R9");
    apply(2'd3, 2'd0, 1, 4'h2, 0, 0, 0, 2'd0, 0, 8'h01, 8'h00, "R9");
    apply(2'd1, 2'd0, 1, 4'h5, 0, 0, 0, 2'd0, 0, 8'h02, 8'h00, "R5");

    // R6: logic sweep, carry-in bit ignored
    for (int g = 8; g < 16; g++)
      apply(2'd0, 2'd1, 0, 4'(g), 0, 0, 0, 2'd0, 0, 8'h00, 8'h00, "R6");

    // R7: shifter both ways, register and constant source
    apply(2'd0, 2'd1, 0, 4'h2, 1, 0, 0, 2'd0, 0, 8'h00, 8'h00, "R7");
    apply(2'd0, 2'd1, 0, 4'h2, 1, 1, 0, 2'd0, 0, 8'h00, 8'h00, "R7");
    apply(2'd0, 2'd0, 1, 4'h3, 1, 1, 0, 2'd0, 0, 8'h80, 8'h00, "R7");
    apply(2'd0, 2'd0, 0, 4'h0, 1, 0, 0, 2'd2, 1, 8'h00, 8'h00, "R7");
    rd(2'd2, 2'd2, "R7");

    // R10: zero and negative
    apply(2'd1, 2'd1, 0, 4'h5, 0, 0, 0, 2'd0, 0, 8'h00, 8'h00, "R10");
    apply(2'd1, 2'd0, 0, 4'h0, 0, 0, 0, 2'd0, 0, 8'h00, 8'h00, "R10");

    // R2: ALU result written back, neighbours untouched
    apply(2'd0, 2'd3, 0, 4'h2, 0, 0, 0, 2'd1, 1, 8'h00, 8'h00, "R2");
    rd(2'd1, 2'd0, "R2");
    rd(2'd2, 2'd3, "R2");
    apply(2'd1, 2'd1, 0, 4'hB, 0, 0, 0, 2'd3, 1, 8'h00, 8'h00, "R2");
    rd(2'd3, 2'd0, "R2");

    @(negedge clk);
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule